// File: doc/BRIEF.md
# Isochronous Cycle Timer and Event Monitor

This block keeps the cycle time of a node on an isochronous serial bus and turns timer and bus events into status outputs. The timer holds three fields: a cycle offset that advances on every rate tick, a cycle number that advances each time the offset wraps, and a seconds count that advances each time the cycle number wraps. A node that is not the cycle master follows the master's time. Each cycle-start packet it receives loads the timer from the packet's timestamp.

Around the timer, a two-state phase machine follows the isochronous cycle. In state `PH_WAIT` no cycle start is outstanding. A cycle-start pulse (sent or received) moves it to `PH_ISO` (transition *start*). A fair gap seen in `PH_ISO` ends the cycle and returns it to `PH_WAIT` (transition *done*). A fair gap in `PH_WAIT` leaves the state unchanged (transition *idle gap*). A further cycle start in `PH_ISO` keeps the machine there. Beside the machine, a pending flag is raised when the offset wraps and is cleared when the cycle completes. A loss watcher counts offset wraps that pass with no cycle start while the node is not master, and it reports a lost cycle.

Top module: `cyc_timer_mon`

## Requirements
- R1: After synchronous active-low reset, `cycle_time` is 0 and every pulse output and `cycle_pending` is 0.
- R2: On each clock with `tick` high and no load, the offset (bits [11:0] of `cycle_time`) increments. After `OFF_MAX` (3071 by default) it wraps to 0 and the cycle number (bits [24:12]) increments. With neither `tick` nor a load, `cycle_time` holds.
- R3: When the offset wraps while the cycle number equals `CN_MAX` (7999 by default), the cycle number becomes 0 and the seconds field (bits [31:25]) increments.
- R4: `pulse_second` is high for one cycle, on the clock after a tick edge at which counting changed bits [12:6] of the cycle number, including the wrap from `CN_MAX` to 0.
- R5: `cs_seen` with `is_master` low loads `cycle_time` from `cs_time` and takes priority over `tick`. `cs_seen` with `is_master` high leaves `cycle_time` unchanged.
- R6: `pulse_start` is high for one cycle, on the clock after each `cs_seen`, whatever the value of `is_master`.
- R7: `pulse_done` is high for one cycle after the first `fair_gap` that follows a `cs_seen`. A `fair_gap` with no cycle start outstanding, or one arriving in the same cycle as the first `cs_seen`, produces no `pulse_done`.
- R8: `cycle_pending` rises at the edge where the offset wraps to 0 and falls together with `pulse_done`.
- R9: With `is_master` low, `pulse_lost` is high for one cycle when `LOST_CYCLES` (2) offset wraps have passed with no `cs_seen`. The count then restarts. With `is_master` high, `pulse_lost` stays low.
- R10: Any `cs_seen` restarts the missed-cycle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Rate tick enable for the offset counter |
| is_master | input | 1 | Node is the cycle master |
| cs_seen | input | 1 | Cycle-start packet sent or received this cycle |
| fair_gap | input | 1 | Fair gap detected on the bus this cycle |
| cs_time | input | 32 | Timestamp carried by a received cycle start |
| cycle_time | output | 32 | Timer value {seconds, cycle number, offset} |
| pulse_second | output | 1 | Upper cycle-number bits advanced |
| pulse_start | output | 1 | Cycle start observed |
| pulse_done | output | 1 | Isochronous cycle completed |
| pulse_lost | output | 1 | Cycles missed without a cycle start |
| cycle_pending | output | 1 | Offset wrapped and the cycle is not yet complete |

## Verification
The hardest conditions to reach are the seconds-level events: at default rates the upper cycle-number bits change only every 64 cycles of 3072 ticks each. The stimulus therefore shrinks `OFF_MAX` to 7 and uses a non-master cycle-start load to place the timer just before a boundary. These boundaries are cycle number 63 and cycle number 7999. A single tick then crosses the boundary. The same load also places the offset at 0, so the loss watcher's two-wrap window lines up with a known number of ticks.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_ISO  = 1'b1
    } phase_t;
endpackage

// File: rtl/cyc_time_count.sv
module cyc_time_count #(
    parameter int OFF_W   = 12,
    parameter int CN_W    = 13,
    parameter int SEC_W   = 7,
    parameter int OFF_MAX = 3071,
    parameter int CN_MAX  = 7999,
    parameter int LOW_W   = 6,
    localparam int TIME_W = OFF_W + CN_W + SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] time_q,
    output logic              off_wrap,
    output logic              sec_step
);
    logic [OFF_W-1:0] off_q;
    logic [CN_W-1:0]  cn_q;
    logic [SEC_W-1:0] sec_q;
    logic [CN_W-1:0]  cn_next;
    logic             cn_wrap;

    always_comb begin
        off_wrap = tick && !load && (off_q == OFF_W'(OFF_MAX));
        cn_wrap  = off_wrap && (cn_q == CN_W'(CN_MAX));
        cn_next  = cn_wrap ? '0 : cn_q + 1'b1;
        sec_step = off_wrap && (cn_next[CN_W-1:LOW_W] != cn_q[CN_W-1:LOW_W]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            cn_q  <= '0;
            sec_q <= '0;
        end else if (load) begin
            {sec_q, cn_q, off_q} <= load_val;
        end else if (tick) begin
            if (off_wrap) begin
                off_q <= '0;
                cn_q  <= cn_next;
                if (cn_wrap) sec_q <= sec_q + 1'b1;
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    assign time_q = {sec_q, cn_q, off_q};
endmodule

// File: rtl/cyc_loss_watch.sv
module cyc_loss_watch #(
    parameter int LOST_CYCLES = 2,
    localparam int LC_W = $clog2(LOST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic cs_seen,
    input  logic off_wrap,
    output logic lost_q
);
    logic [LC_W-1:0] miss_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= '0;
            lost_q <= 1'b0;
        end else begin
            lost_q <= 1'b0;
            if (is_master || cs_seen) begin
                miss_q <= '0;
            end else if (off_wrap) begin
                if (miss_q == LC_W'(LOST_CYCLES - 1)) begin
                    miss_q <= '0;
                    lost_q <= 1'b1;
                end else begin
                    miss_q <= miss_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cyc_phase_fsm.sv
module cyc_phase_fsm
    import cyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_seen,
    input  logic fair_gap,
    input  logic off_wrap,
    output logic start_q,
    output logic done_q,
    output logic pend_q
);
    phase_t state_q, state_d;
    logic   done_d;

    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        unique case (state_q)
            PH_WAIT: if (cs_seen) state_d = PH_ISO;
            PH_ISO: begin
                if (fair_gap) begin
                    done_d  = 1'b1;
                    state_d = cs_seen ? PH_ISO : PH_WAIT;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            start_q <= cs_seen;
            done_q  <= done_d;
            if (off_wrap)    pend_q <= 1'b1;
            else if (done_d) pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cyc_timer_mon.sv
module cyc_timer_mon #(
    parameter int OFF_W       = 12,
    parameter int CN_W        = 13,
    parameter int SEC_W       = 7,
    parameter int OFF_MAX     = 3071,
    parameter int CN_MAX      = 7999,
    parameter int LOW_W       = 6,
    parameter int LOST_CYCLES = 2,
    localparam int TIME_W     = OFF_W + CN_W + SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              is_master,
    input  logic              cs_seen,
    input  logic              fair_gap,
    input  logic [TIME_W-1:0] cs_time,
    output logic [TIME_W-1:0] cycle_time,
    output logic              pulse_second,
    output logic              pulse_start,
    output logic              pulse_done,
    output logic              pulse_lost,
    output logic              cycle_pending
);
    logic load;
    logic off_wrap;
    logic sec_step;

    assign load = cs_seen && !is_master;

    cyc_time_count #(
        .OFF_W(OFF_W), .CN_W(CN_W), .SEC_W(SEC_W),
        .OFF_MAX(OFF_MAX), .CN_MAX(CN_MAX), .LOW_W(LOW_W)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_val(cs_time), .time_q(cycle_time),
        .off_wrap(off_wrap), .sec_step(sec_step)
    );

    cyc_phase_fsm u_phase (
        .clk(clk), .rst_n(rst_n), .cs_seen(cs_seen), .fair_gap(fair_gap),
        .off_wrap(off_wrap), .start_q(pulse_start), .done_q(pulse_done),
        .pend_q(cycle_pending)
    );

    cyc_loss_watch #(.LOST_CYCLES(LOST_CYCLES)) u_loss (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .cs_seen(cs_seen),
        .off_wrap(off_wrap), .lost_q(pulse_lost)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_second <= 1'b0;
        else        pulse_second <= sec_step;
    end
endmodule

// File: rtl/cyc_timer_mon_chk.sv
module cyc_timer_mon_chk #(
    parameter int OFF_W   = 12,
    parameter int TIME_W  = 32,
    parameter int OFF_MAX = 3071
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              is_master,
    input logic              cs_seen,
    input logic              fair_gap,
    input logic [TIME_W-1:0] cycle_time,
    input logic              pulse_second,
    input logic              pulse_done,
    input logic              pulse_lost,
    input logic              cycle_pending
);
    logic [OFF_W-1:0] off;
    assign off = cycle_time[OFF_W-1:0];

    assert_offset_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick) && !$past(cs_seen && !is_master) |->
        off == (($past(off) == OFF_W'(OFF_MAX)) ? '0 : $past(off) + 1'b1));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tick) && !$past(cs_seen && !is_master) |->
        $stable(cycle_time));

    assert_second_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_second |-> off == '0);

    assert_done_after_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_done |-> $past(fair_gap));

    assert_pending_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cycle_pending) |-> off == '0);

    assert_pending_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cycle_pending) |-> pulse_done);

    assert_lost_nonmaster_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_lost |-> !$past(is_master));

    assert_lost_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_lost |-> !$past(cs_seen));
endmodule

bind cyc_timer_mon cyc_timer_mon_chk #(
    .OFF_W(OFF_W), .TIME_W(TIME_W), .OFF_MAX(OFF_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .is_master(is_master),
    .cs_seen(cs_seen), .fair_gap(fair_gap), .cycle_time(cycle_time),
    .pulse_second(pulse_second), .pulse_done(pulse_done),
    .pulse_lost(pulse_lost), .cycle_pending(cycle_pending)
);

// File: tb/cyc_timer_mon_tb.sv
module cyc_timer_mon_tb;
    localparam int OFFM = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        is_master = 1'b1;
    logic        cs_seen = 1'b0;
    logic        fair_gap = 1'b0;
    logic [31:0] cs_time = '0;
    logic [31:0] cycle_time;
    logic        pulse_second, pulse_start, pulse_done, pulse_lost, cycle_pending;

    int n_tests = 0;
    int n_fail  = 0;
    int n_lost  = 0;

    always #5 clk = ~clk;

    cyc_timer_mon #(.OFF_MAX(OFFM)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .is_master(is_master),
        .cs_seen(cs_seen), .fair_gap(fair_gap), .cs_time(cs_time),
        .cycle_time(cycle_time), .pulse_second(pulse_second),
        .pulse_start(pulse_start), .pulse_done(pulse_done),
        .pulse_lost(pulse_lost), .cycle_pending(cycle_pending)
    );

    // {cs_seen, fair_gap, expected start, expected done}
    localparam logic [3:0] PHASE_TBL [7] = '{
        4'b0100,   // idle gap ignored (R7)
        4'b1010,   // start (R6)
        4'b0000,
        4'b0101,   // done (R7)
        4'b0100,   // second gap ignored (R7)
        4'b1110,   // start and gap together in wait (R7)
        4'b0101    // done (R7)
    };

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (pulse_lost) n_lost++;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick = 1'b0;
    endtask

    task automatic load(input logic [6:0] s, input logic [12:0] c, input logic [11:0] o);
        cs_time = {s, c, o};
        cs_seen = 1'b1;
        step();
        cs_seen = 1'b0;
    endtask

    function automatic logic [31:0] tv(input logic [6:0] s, input logic [12:0] c, input logic [11:0] o);
        return {s, c, o};
    endfunction

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;
        // R1 reset state
        check(cycle_time == 0 && !pulse_second && !pulse_start && !pulse_done &&
              !pulse_lost && !cycle_pending, "R1",
              {cycle_time, pulse_start, pulse_done, pulse_lost, cycle_pending}, 0);

        // Phase-machine table, master node, no ticks
        for (int k = 0; k < 7; k++) begin
            cs_seen  = PHASE_TBL[k][3];
            fair_gap = PHASE_TBL[k][2];
            step();
            cs_seen  = 1'b0;
            fair_gap = 1'b0;
            check(pulse_start == PHASE_TBL[k][1], "R6", pulse_start, PHASE_TBL[k][1]);
            check(pulse_done == PHASE_TBL[k][0], "R7", pulse_done, PHASE_TBL[k][0]);
        end

        // R2 hold without tick
        step();
        check(cycle_time == 0, "R2 hold", cycle_time, 0);
        // R2 counting and wrap
        ticks(OFFM);
        check(cycle_time == tv(0, 0, OFFM), "R2 count", cycle_time, tv(0, 0, OFFM));
        check(!cycle_pending, "R8 before wrap", cycle_pending, 0);
        ticks(1);
        check(cycle_time == tv(0, 1, 0), "R2 wrap", cycle_time, tv(0, 1, 0));
        check(cycle_pending, "R8 set", cycle_pending, 1);
        // R5 master cycle start does not load; pending held until done
        cs_time = tv(9, 9, 3);
        cs_seen = 1'b1;
        step();
        cs_seen = 1'b0;
        check(cycle_time == tv(0, 1, 0), "R5 master no load", cycle_time, tv(0, 1, 0));
        check(cycle_pending, "R8 held", cycle_pending, 1);
        fair_gap = 1'b1;
        step();
        fair_gap = 1'b0;
        check(pulse_done && !cycle_pending, "R8 clear", {pulse_done, cycle_pending}, 2'b10);

        // R4 cycle-second at cycle number 63 -> 64
        is_master = 1'b0;
        load(3, 63, OFFM);
        check(cycle_time == tv(3, 63, OFFM), "R5 load", cycle_time, tv(3, 63, OFFM));
        is_master = 1'b1;
        check(!pulse_second, "R4 idle", pulse_second, 0);
        ticks(1);
        check(pulse_second && cycle_time == tv(3, 64, 0), "R4",
              {pulse_second, cycle_time}, {1'b1, tv(3, 64, 0)});
        ticks(1);
        check(!pulse_second, "R4 one cycle", pulse_second, 0);
        ticks(OFFM);
        check(!pulse_second && cycle_time == tv(3, 65, 0), "R4 no step",
              {pulse_second, cycle_time}, {1'b0, tv(3, 65, 0)});

        // R3 cycle number wrap into seconds
        is_master = 1'b0;
        load(5, 7999, OFFM);
        is_master = 1'b1;
        ticks(1);
        check(cycle_time == tv(6, 0, 0), "R3", cycle_time, tv(6, 0, 0));
        check(pulse_second, "R4 at wrap", pulse_second, 1);

        // R5 load wins over tick
        is_master = 1'b0;
        tick = 1'b1;
        load(1, 2, 3);
        tick = 1'b0;
        check(cycle_time == tv(1, 2, 3), "R5 priority", cycle_time, tv(1, 2, 3));

        // R9 lost after two missed cycles
        load(0, 10, 0);
        n_lost = 0;
        ticks(2 * (OFFM + 1) - 1);
        check(n_lost == 0, "R9 before", n_lost, 0);
        ticks(1);
        check(pulse_lost, "R9 fire", pulse_lost, 1);
        n_lost = 0;
        ticks(2 * (OFFM + 1));
        check(n_lost == 1, "R9 restart", n_lost, 1);

        // R10 cycle start restarts the count
        n_lost = 0;
        ticks(OFFM + 1);
        load(0, 20, 0);
        ticks(OFFM + 1);
        check(n_lost == 0, "R10", n_lost, 0);

        // R9 master never loses
        is_master = 1'b1;
        n_lost = 0;
        ticks(4 * (OFFM + 1));
        check(n_lost == 0, "R9 master", n_lost, 0);

        // R1 reset mid-run
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check(cycle_time == 0 && !cycle_pending, "R1 again",
              {cycle_time, cycle_pending}, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule